// File: doc/BRIEF.md
# Encoded-Ratio Host Clock Divider

This block derives a host-controller clock from a fast core clock. A 3-bit code picks one of eight divide ratios. The ratio set is not uniform: alongside the powers of two it holds 6 and 24. A divider-reset input parks the divider with its output low. The code is captured only while that reset is held, so a ratio change always starts from a clean phase. A registered enable gates the final clock. A bypass select swaps the divided clock for a clock arriving on an external pin.

A combinational helper takes a core-clock frequency in hertz. It reports the lowest code whose divided frequency falls inside an inclusive window, 150 MHz to 300 MHz by default. When no ratio reaches the window it raises an error. The control agent reads the helper's code, holds the divider reset, writes the code, and then releases the reset. The captured code and enable are brought back out so the agent can confirm they were accepted.

Top module: `host_clk_gen`

## Requirements
- R1: Codes 0 to 7 select ratios 1, 2, 4, 6, 8, 16, 24 and 32 in that order. For every ratio N of 2 or more, the divided output is high for N/2 core cycles and low for N/2 core cycles.
- R2: While `divRst` is high, the divided clock is held low and its phase counter is idle.
- R3: On every core edge where `divRst` is sampled high, `ratioCode` is captured. After that edge, `activeCode` shows the captured value.
- R4: A change on `ratioCode` while `divRst` is low has no effect on `activeCode` or on the output period until the next divider reset.
- R5: After release, the divided output first rises on the (N/2)-th core rising edge at which `divRst` is sampled low. It never rises earlier.
- R6: `clkEn` is registered on each core edge and shown on `activeEn`. While the registered enable is 0, `hostClk` is 0.
- R7: With `bypassSel` = 1, `hostClk` equals `extClk` AND the registered enable, whatever the divider state.
- R8: With code 0, `hostClk` follows `coreClk` once the divider is running and enabled. During divider reset it stays low.
- R9: `autoCode` is the lowest code whose ratio gives floor(`coreFreqHz`/ratio) within [150 MHz, 300 MHz] inclusive, and `autoErr` is then 0.
- R10: When no code meets the window, `autoErr` is 1 and `autoCode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| coreClk | input | 1 | Fast core clock being divided |
| rstN | input | 1 | Asynchronous active-low reset |
| extClk | input | 1 | External pin clock for bypass |
| divRst | input | 1 | Divider reset; code capture while high |
| clkEn | input | 1 | Output clock enable |
| bypassSel | input | 1 | 0 = divided core clock, 1 = external clock |
| ratioCode | input | 3 | Divide-ratio select code |
| coreFreqHz | input | 32 | Core clock frequency in Hz for auto-select |
| hostClk | output | 1 | Gated host-controller clock |
| activeCode | output | 3 | Captured ratio code readback |
| activeEn | output | 1 | Registered enable readback |
| autoCode | output | 3 | Auto-selected ratio code |
| autoErr | output | 1 | No ratio meets the frequency window |

## Verification
Every one of the eight codes is run for several output periods, and the divided clock is compared each cycle against a phase count. This separates the uneven ratios 6 and 24 from their power-of-two neighbours. It also catches any off-by-one in the half-period or in the first edge after release. A code written mid-run, an enable dropped mid-run, and a bypass interval driven by an unrelated external clock show whether the capture, the gate and the mux each act alone. The helper is fed frequencies that land exactly on both window edges and just below the lower one. It also gets values that push the choice to the middle codes and values that miss the window entirely, which tells an inclusive, first-match scan apart from an exclusive or last-match one.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
  localparam int CODE_W    = 3;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int MAX_RATIO = 32;
  localparam int RATIO_W   = $clog2(MAX_RATIO) + 1;
  localparam int CNT_W     = $clog2(MAX_RATIO / 2);

  // Strobes from control to datapath
  typedef struct packed {
    logic hold;      // divider parked
    logic flip;      // toggle divided clock this edge
    logic passThru;  // ratio 1 selected
    logic run;       // divider released
  } divStrobe_t;

  function automatic logic [RATIO_W-1:0] ratioOf(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    ratioOf = RATIO_W'(1);
      3'd1:    ratioOf = RATIO_W'(2);
      3'd2:    ratioOf = RATIO_W'(4);
      3'd3:    ratioOf = RATIO_W'(6);
      3'd4:    ratioOf = RATIO_W'(8);
      3'd5:    ratioOf = RATIO_W'(16);
      3'd6:    ratioOf = RATIO_W'(24);
      default: ratioOf = RATIO_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/hcd_ctrl.sv
module hcd_ctrl
  import hcd_pkg::*;
(
  input  logic              coreClk,
  input  logic              rstN,
  input  logic              divRst,
  input  logic [CODE_W-1:0] ratioCode,
  output logic [CODE_W-1:0] activeCode,
  output divStrobe_t        strobes
);
  logic [CODE_W-1:0] codeQ;
  logic [CNT_W-1:0]  phaseCnt;
  logic [CNT_W-1:0]  halfLast;
  logic [RATIO_W-1:0] ratio;
  logic              runQ;

  assign ratio = ratioOf(codeQ);

  always_comb begin
    if (ratio < RATIO_W'(2)) halfLast = '0;
    else                     halfLast = CNT_W'((ratio >> 1) - RATIO_W'(1));
  end

  always_ff @(posedge coreClk or negedge rstN) begin
    if (!rstN) begin
      codeQ    <= '0;
      phaseCnt <= '0;
      runQ     <= 1'b0;
    end else if (divRst) begin
      codeQ    <= ratioCode;
      phaseCnt <= '0;
      runQ     <= 1'b0;
    end else begin
      runQ     <= 1'b1;
      phaseCnt <= (phaseCnt == halfLast) ? '0 : phaseCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobes.hold     = divRst;
    strobes.flip     = !divRst && (phaseCnt == halfLast);
    strobes.passThru = (codeQ == '0);
    strobes.run      = runQ;
  end

  assign activeCode = codeQ;
endmodule

// File: rtl/hcd_datapath.sv
module hcd_datapath
  import hcd_pkg::*;
(
  input  logic       coreClk,
  input  logic       rstN,
  input  logic       extClk,
  input  logic       clkEn,
  input  logic       bypassSel,
  input  divStrobe_t strobes,
  output logic       divQ,
  output logic       enQ,
  output logic       hostClk
);
  logic innerClk;

  always_ff @(posedge coreClk or negedge rstN) begin
    if (!rstN) begin
      divQ <= 1'b0;
      enQ  <= 1'b0;
    end else begin
      enQ <= clkEn;
      if (strobes.hold)      divQ <= 1'b0;
      else if (strobes.flip) divQ <= ~divQ;
    end
  end

  always_comb begin
    if (strobes.passThru) innerClk = coreClk & strobes.run;
    else                  innerClk = divQ;
    hostClk = (bypassSel ? extClk : innerClk) & enQ;
  end
endmodule

// File: rtl/hcd_autosel.sv
module hcd_autosel
  import hcd_pkg::*;
#(
  parameter int          FREQ_W = 32,
  parameter int unsigned MIN_HZ = 150_000_000,
  parameter int unsigned MAX_HZ = 300_000_000
) (
  input  logic [FREQ_W-1:0] coreFreqHz,
  output logic [CODE_W-1:0] autoCode,
  output logic              autoErr
);
  localparam logic [FREQ_W-1:0] LO = FREQ_W'(MIN_HZ);
  localparam logic [FREQ_W-1:0] HI = FREQ_W'(MAX_HZ);

  logic [NUM_CODES-1:0] fits;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_fit
    logic [FREQ_W-1:0] outHz;
    assign outHz   = coreFreqHz / FREQ_W'(ratioOf(CODE_W'(g)));
    assign fits[g] = (outHz >= LO) && (outHz <= HI);
  end

  always_comb begin
    autoCode = '0;
    autoErr  = 1'b1;
    for (int i = NUM_CODES - 1; i >= 0; i--) begin
      if (fits[i]) begin
        autoCode = CODE_W'(i);
        autoErr  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/host_clk_gen.sv
module host_clk_gen
  import hcd_pkg::*;
#(
  parameter int          FREQ_W = 32,
  parameter int unsigned MIN_HZ = 150_000_000,
  parameter int unsigned MAX_HZ = 300_000_000
) (
  input  logic              coreClk,
  input  logic              rstN,
  input  logic              extClk,
  input  logic              divRst,
  input  logic              clkEn,
  input  logic              bypassSel,
  input  logic [CODE_W-1:0] ratioCode,
  input  logic [FREQ_W-1:0] coreFreqHz,
  output logic              hostClk,
  output logic [CODE_W-1:0] activeCode,
  output logic              activeEn,
  output logic [CODE_W-1:0] autoCode,
  output logic              autoErr
);
  divStrobe_t strobes;
  logic       divQ;

  hcd_ctrl u_ctrl (
    .coreClk    (coreClk),
    .rstN       (rstN),
    .divRst     (divRst),
    .ratioCode  (ratioCode),
    .activeCode (activeCode),
    .strobes    (strobes)
  );

  hcd_datapath u_dp (
    .coreClk   (coreClk),
    .rstN      (rstN),
    .extClk    (extClk),
    .clkEn     (clkEn),
    .bypassSel (bypassSel),
    .strobes   (strobes),
    .divQ      (divQ),
    .enQ       (activeEn),
    .hostClk   (hostClk)
  );

  hcd_autosel #(.FREQ_W(FREQ_W), .MIN_HZ(MIN_HZ), .MAX_HZ(MAX_HZ)) u_auto (
    .coreFreqHz (coreFreqHz),
    .autoCode   (autoCode),
    .autoErr    (autoErr)
  );
endmodule

// File: rtl/host_clk_gen_chk.sv
module host_clk_gen_chk
  import hcd_pkg::*;
#(
  parameter int          FREQ_W = 32,
  parameter int unsigned MIN_HZ = 150_000_000,
  parameter int unsigned MAX_HZ = 300_000_000
) (
  input logic              coreClk,
  input logic              rstN,
  input logic              divRst,
  input logic              clkEn,
  input logic [CODE_W-1:0] ratioCode,
  input logic [CODE_W-1:0] activeCode,
  input logic              activeEn,
  input logic              divQ,
  input logic [FREQ_W-1:0] coreFreqHz,
  input logic [CODE_W-1:0] autoCode,
  input logic              autoErr
);
  logic [FREQ_W-1:0] pickedHz;
  assign pickedHz = coreFreqHz / FREQ_W'(ratioOf(autoCode));

  p_idle_hold_r2: assert property (@(posedge coreClk) disable iff (!rstN)
    divRst |=> !divQ);

  p_code_load_r3: assert property (@(posedge coreClk) disable iff (!rstN)
    divRst |=> activeCode == $past(ratioCode));

  p_code_frozen_r4: assert property (@(posedge coreClk) disable iff (!rstN)
    !divRst |=> $stable(activeCode));

  p_en_track_r6: assert property (@(posedge coreClk) disable iff (!rstN)
    $past(rstN) |-> activeEn == $past(clkEn));

  p_auto_window_r9: assert property (@(posedge coreClk) disable iff (!rstN)
    !autoErr |-> (pickedHz >= FREQ_W'(MIN_HZ)) && (pickedHz <= FREQ_W'(MAX_HZ)));

  p_auto_err_r10: assert property (@(posedge coreClk) disable iff (!rstN)
    autoErr |-> autoCode == '0);
endmodule

bind host_clk_gen host_clk_gen_chk #(.FREQ_W(FREQ_W), .MIN_HZ(MIN_HZ), .MAX_HZ(MAX_HZ)) u_chk (
  .coreClk    (coreClk),
  .rstN       (rstN),
  .divRst     (divRst),
  .clkEn      (clkEn),
  .ratioCode  (ratioCode),
  .activeCode (activeCode),
  .activeEn   (activeEn),
  .divQ       (divQ),
  .coreFreqHz (coreFreqHz),
  .autoCode   (autoCode),
  .autoErr    (autoErr)
);

// File: tb/test_host_clk_gen.sv
`timescale 1ns/100ps
module test_host_clk_gen;
  localparam int MIN_HZ = 150_000_000;
  localparam int MAX_HZ = 300_000_000;
  localparam int RATIOS [8] = '{1, 2, 4, 6, 8, 16, 24, 32};

  logic        clk = 1'b0;
  logic        extClk = 1'b0;
  logic        rstN = 1'b0;
  logic        divRst = 1'b1;
  logic        clkEn = 1'b0;
  logic        bypassSel = 1'b0;
  logic [2:0]  ratioCode = 3'd0;
  logic [31:0] coreFreqHz = 32'd0;
  logic        hostClk;
  logic [2:0]  activeCode;
  logic        activeEn;
  logic [2:0]  autoCode;
  logic        autoErr;

  int total = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural model state
  int mCode = 0;
  int mRun = 0;
  int mEn = 0;
  int mEdges = 0;

  host_clk_gen i_host_clk_gen (
    .coreClk(clk), .rstN(rstN), .extClk(extClk), .divRst(divRst),
    .clkEn(clkEn), .bypassSel(bypassSel), .ratioCode(ratioCode),
    .coreFreqHz(coreFreqHz), .hostClk(hostClk), .activeCode(activeCode),
    .activeEn(activeEn), .autoCode(autoCode), .autoErr(autoErr)
  );

  always #4 clk = ~clk;
  initial begin
    #1.3;
    forever #3.5 extClk = ~extClk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      finishRun();
    end
  end

  // reference model, inputs are stable at posedge
  always @(posedge clk) begin
    if (!rstN) begin
      mCode = 0; mRun = 0; mEn = 0; mEdges = 0;
    end else begin
      mEn = clkEn;
      if (divRst) begin
        mCode = ratioCode; mRun = 0; mEdges = 0;
      end else begin
        mRun = 1; mEdges++;
      end
    end
  end

  // compare on every falling edge (coreClk low)
  always @(negedge clk) begin
    if (rstN && !done) begin
      int exp;
      string tag;
      if (bypassSel) begin
        exp = extClk & mEn; tag = "R7 bypass";
      end else if (mCode == 0) begin
        exp = 0; tag = "R8 pass-through low phase";
      end else if (mEn == 0) begin
        exp = 0; tag = "R6 gated";
      end else if (!mRun) begin
        exp = 0; tag = "R2 held";
      end else begin
        exp = ((mEdges / (RATIOS[mCode] / 2)) % 2);
        tag = (mEdges < RATIOS[mCode] / 2) ? "R5 first edge" : "R1 ratio";
      end
      check(hostClk === exp[0], tag, hostClk, exp);
      check(activeCode == 3'(mCode), "R3/R4 code readback", activeCode, mCode);
      check(activeEn == mEn[0], "R6 enable readback", activeEn, mEn);
    end
  end

  task automatic drive();
    @(posedge clk); #2;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) drive();
  endtask

  task automatic runCode(input int c, input int periods);
    divRst = 1'b1; ratioCode = 3'(c); clkEn = 1'b1;
    waitCycles(3);
    divRst = 1'b0;
    waitCycles(periods * RATIOS[c] + 3);
  endtask

  task automatic checkAuto(input int f);
    int expCode = 0;
    int expErr = 1;
    coreFreqHz = 32'(f);
    #1;
    for (int c = 0; c < 8; c++) begin
      int outHz = int'(longint'(unsigned'(f)) / RATIOS[c]);
      if (expErr == 1 && outHz >= MIN_HZ && outHz <= MAX_HZ) begin
        expErr = 0; expCode = c;
      end
    end
    if (expErr) begin
      check(autoErr === 1'b1, "R10 error flag", autoErr, 1);
      check(autoCode === 3'd0, "R10 error code", autoCode, 0);
    end else begin
      check(autoErr === 1'b0, "R9 no error", autoErr, 0);
      check(autoCode === 3'(expCode), "R9 first fit", autoCode, expCode);
    end
  endtask

  initial begin
    waitCycles(3);
    #2;
    check(hostClk === 1'b0, "R2 reset output", hostClk, 0);
    check(activeCode === 3'd0, "R3 reset code", activeCode, 0);
    check(activeEn === 1'b0, "R6 reset enable", activeEn, 0);
    rstN = 1'b1;
    drive();

    // R1 / R5: every code, several periods
    for (int c = 1; c < 8; c++) runCode(c, 3);

    // R8: divide-by-1 pass-through, checked while coreClk is high
    divRst = 1'b1; ratioCode = 3'd0; clkEn = 1'b1;
    waitCycles(2);
    @(posedge clk); #1;
    check(hostClk === 1'b0, "R8 low during divider reset", hostClk, 0);
    #1; divRst = 1'b0;
    waitCycles(2);
    @(posedge clk); #1;
    check(hostClk === 1'b1, "R8 follows core high phase", hostClk, 1);
    waitCycles(4);

    // R4: code change while running is ignored
    runCode(3, 2);
    ratioCode = 3'd7;
    waitCycles(20);
    check(activeCode === 3'd3, "R4 code held while running", activeCode, 3);
    divRst = 1'b1;
    waitCycles(2);
    check(activeCode === 3'd7, "R3 code taken on reset", activeCode, 7);
    divRst = 1'b0;
    waitCycles(70);

    // R6: enable dropped mid-run then restored
    clkEn = 1'b0;
    waitCycles(40);
    clkEn = 1'b1;
    waitCycles(40);

    // R7: bypass to external clock, with and without enable
    bypassSel = 1'b1;
    waitCycles(30);
    clkEn = 1'b0;
    waitCycles(10);
    clkEn = 1'b1; divRst = 1'b1;
    waitCycles(10);
    bypassSel = 1'b0; divRst = 1'b0;
    waitCycles(10);

    // R9 / R10: auto-select
    checkAuto(250_000_000);
    checkAuto(150_000_000);
    checkAuto(300_000_000);
    checkAuto(600_000_000);
    checkAuto(800_000_000);
    checkAuto(1_200_000_000);
    checkAuto(300_000_001);
    checkAuto(149_999_999);
    checkAuto(100_000_000);
    checkAuto(0);
    checkAuto(32'hFFFF_FFFF);

    done = 1;
    finishRun();
  end
endmodule